// File: doc/BRIEF.md
# Dual-Address Interrupt Enable Register Bank

This block holds the enable state of an interrupt controller in a small bank of memory-mapped registers. There are two kinds of register. A mask register treats every bit as its own slot. A priority register splits its width into equal fields, and each field is one slot. A register can be reached through a pair of addresses, one that sets bits and one that clears them. It can also be reached through a single address, which replaces the whole value. Address comparison uses only the low 29 bits of the bus address.

On every accepted write the bank works out the register's new value and compares it slot by slot with the old value. For each slot that changed it raises a one-cycle enable pulse if the new slot value is non-zero, and a disable pulse if it is zero. These pulses go to the interrupt source or group mapped to that slot, and the downstream source logic counts them. Reads return the stored value of the addressed register. An address that matches no register reads as zero. A write to such an address is dropped and raises an error pulse.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset every register holds zero, no enable or disable pulse is raised and `err` is low.
- R2: Only address bits [28:0] take part in decoding. A write whose upper bits differ but whose low 29 bits equal a register address acts on that register.
- R3: For a register with both a set and a clear address, a write to the set address stores old value OR write data.
- R4: For such a register, a write to the clear address stores old value AND NOT write data.
- R5: A register with only one address stores the write data unchanged. This applies to a mask register with only a clear address and to a priority register with only a set address.
- R6: Slot k of a register covers the bits starting at (SLOTS-1-k)×SLOT_W, so slot 0 is the most significant bit or field. Mask registers use 1-bit slots; priority registers use FIELD_W-bit slots. Mask register i, slot k drives event index i×REG_W+k. Priority register j, slot k drives index N_MASK×REG_W + j×(REG_W/FIELD_W) + k.
- R7: For each slot whose bits differ between the old and new value, exactly one pulse is raised: `evt_en` if the new slot value is non-zero, `evt_dis` if it is zero. An unchanged slot raises nothing.
- R8: The register value and the pulses update on the clock edge that samples `we`. The pulses stay high for exactly that one following cycle.
- R9: When an address matches both a mask register and a priority register, the mask register takes the access.
- R10: `rdata` shows the stored value of the register that the current address selects, through either of its addresses.
- R11: An address that matches no register reads zero. A write to it changes no register, raises no pulse and sets `err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Bus address; bits [28:0] are decoded |
| wdata | input | REG_W | Write data |
| we | input | 1 | Write strobe, one access per cycle |
| rdata | output | REG_W | Stored value of the addressed register |
| evt_en | output | N_EVT | One-cycle enable pulse per slot |
| evt_dis | output | N_EVT | One-cycle disable pulse per slot |
| err | output | 1 | One-cycle pulse after a write to an unmapped address |

## Verification
The assertions check several properties on every cycle. A register only changes on a write that selects it. No slot ever raises an enable and a disable together. A pulse appears only in the cycle after a write. A set-address write never clears a bit. At most one register is selected. An error pulse never comes with a slot pulse. Other behaviour needs the bench's scenarios: the exact slot-to-event mapping, the OR and AND-NOT arithmetic, the masking of the upper address bits, the precedence of mask registers on a shared address, and the event sequence as a priority field moves from zero to non-zero, between non-zero values and back to zero.

// File: rtl/intc_bank_pkg.sv
// Package: shared types and constants for the dual-address register bank.
// Assumes bus addresses are at least MATCH_W bits wide.
package intc_bank_pkg;

    // number of low address bits used in decoding
    localparam int MATCH_W = 29;

    // how a selected register combines old value and write data
    typedef enum logic [1:0] {
        WM_DIRECT = 2'd0,
        WM_OR     = 2'd1,
        WM_ANDN   = 2'd2
    } wmode_e;

endpackage

// File: rtl/intc_addr_decode.sv
// Module: address decoder for the register bank.
// Compares the low MATCH_W address bits with each register's set and clear
// addresses; an address of zero in those bits means "absent". The lowest
// register index wins, so mask registers (placed first) beat priority ones.
// Assumes ADDR_W >= MATCH_W.
module intc_addr_decode
    import intc_bank_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_REGS = 4,
    parameter logic [N_REGS-1:0][ADDR_W-1:0] SET_ADDRS = '0,
    parameter logic [N_REGS-1:0][ADDR_W-1:0] CLR_ADDRS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REGS-1:0] sel,
    output wmode_e            mode
);

    logic [N_REGS-1:0] hit_set;
    logic [N_REGS-1:0] hit_clr;
    logic [N_REGS-1:0] is_dual;

    // per-register address compare on the low bits
    for (genvar r = 0; r < N_REGS; r++) begin : g_cmp
        localparam logic [MATCH_W-1:0] SA = SET_ADDRS[r][MATCH_W-1:0];
        localparam logic [MATCH_W-1:0] CA = CLR_ADDRS[r][MATCH_W-1:0];
        assign hit_set[r] = (SA != '0) && (addr[MATCH_W-1:0] == SA);
        assign hit_clr[r] = (CA != '0) && (addr[MATCH_W-1:0] == CA);
        assign is_dual[r] = (SA != '0) && (CA != '0);
    end

    // first-match selection and write-mode choice
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        mode  = WM_DIRECT;
        for (int r = 0; r < N_REGS; r++) begin
            if (!found && (hit_set[r] || hit_clr[r])) begin
                found  = 1'b1;
                sel[r] = 1'b1;
                if (is_dual[r]) mode = hit_set[r] ? WM_OR : WM_ANDN;
                else            mode = WM_DIRECT;
            end
        end
    end

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/intc_reg_slice.sv
// Module: one register of the bank with its slot change detector.
// Stores the value, computes the next value from the write mode and raises
// one registered pulse per slot whose bits changed. Slot k lives at bit
// offset (SLOTS-1-k)*SLOT_W. Assumes REG_W is a multiple of SLOT_W.
module intc_reg_slice
    import intc_bank_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int SLOT_W = 1,
    localparam int SLOTS = REG_W / SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  wmode_e           mode,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value,
    output logic [SLOTS-1:0] en_pulse,
    output logic [SLOTS-1:0] dis_pulse
);

    logic [REG_W-1:0] nxt;
    logic [SLOTS-1:0] en_c;
    logic [SLOTS-1:0] dis_c;

    // next value from the access mode
    always_comb begin
        case (mode)
            WM_OR:   nxt = value | wdata;
            WM_ANDN: nxt = value & ~wdata;
            default: nxt = wdata;
        endcase
    end

    // per-slot change detection, slot 0 at the top of the register
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam int LSB = (SLOTS - 1 - k) * SLOT_W;
        logic changed;
        assign changed  = value[LSB +: SLOT_W] != nxt[LSB +: SLOT_W];
        assign en_c[k]  = changed && (nxt[LSB +: SLOT_W] != '0);
        assign dis_c[k] = changed && (nxt[LSB +: SLOT_W] == '0);
    end

    // value storage and one-cycle event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value     <= '0;
            en_pulse  <= '0;
            dis_pulse <= '0;
        end else begin
            en_pulse  <= '0;
            dis_pulse <= '0;
            if (wr) begin
                value     <= nxt;
                en_pulse  <= en_c;
                dis_pulse <= dis_c;
            end
        end
    end

    // R8
    hold_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> $stable(value));

    // R7
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pulse & dis_pulse) == '0);

    // R8
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_pulse | dis_pulse) != '0) |-> $past(wr));

    // R3
    set_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr) && $past(mode) == WM_OR) |-> ((value & $past(value)) == $past(value)));

endmodule

// File: rtl/intc_dual_bank.sv
// Module: top of the dual-address interrupt enable register bank.
// N_MASK mask registers (1-bit slots) followed by N_PRIO priority registers
// (FIELD_W-bit slots). Each has a set and a clear address; zero means the
// address is absent. Reads are combinational; writes and pulses register.
module intc_dual_bank
    import intc_bank_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int REG_W   = 8,
    parameter int FIELD_W = 4,
    parameter int N_MASK  = 2,
    parameter int N_PRIO  = 2,
    parameter logic [N_MASK-1:0][ADDR_W-1:0] MASK_SET = {32'h0000_0000, 32'h0000_0040},
    parameter logic [N_MASK-1:0][ADDR_W-1:0] MASK_CLR = {32'h0000_0048, 32'h0000_0044},
    parameter logic [N_PRIO-1:0][ADDR_W-1:0] PRIO_SET = {32'h0000_0058, 32'h0000_0050},
    parameter logic [N_PRIO-1:0][ADDR_W-1:0] PRIO_CLR = {32'h0000_0000, 32'h0000_0048},
    localparam int P_SLOTS  = REG_W / FIELD_W,
    localparam int MASK_EVT = N_MASK * REG_W,
    localparam int N_EVT    = MASK_EVT + N_PRIO * P_SLOTS,
    localparam int N_REGS   = N_MASK + N_PRIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              we,
    output logic [REG_W-1:0]  rdata,
    output logic [N_EVT-1:0]  evt_en,
    output logic [N_EVT-1:0]  evt_dis,
    output logic              err
);

    localparam logic [N_REGS-1:0][ADDR_W-1:0] ALL_SET = {PRIO_SET, MASK_SET};
    localparam logic [N_REGS-1:0][ADDR_W-1:0] ALL_CLR = {PRIO_CLR, MASK_CLR};

    logic [N_REGS-1:0]            sel;
    wmode_e                       mode;
    logic [N_REGS-1:0][REG_W-1:0] vals;

    intc_addr_decode #(
        .ADDR_W(ADDR_W), .N_REGS(N_REGS),
        .SET_ADDRS(ALL_SET), .CLR_ADDRS(ALL_CLR)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .mode(mode)
    );

    // mask registers: one slot per bit
    for (genvar i = 0; i < N_MASK; i++) begin : g_mask
        intc_reg_slice #(.REG_W(REG_W), .SLOT_W(1)) u_reg (
            .clk(clk), .rst_n(rst_n), .wr(we && sel[i]), .mode(mode),
            .wdata(wdata), .value(vals[i]),
            .en_pulse(evt_en[i*REG_W +: REG_W]),
            .dis_pulse(evt_dis[i*REG_W +: REG_W])
        );
    end

    // priority registers: one slot per field
    for (genvar j = 0; j < N_PRIO; j++) begin : g_prio
        intc_reg_slice #(.REG_W(REG_W), .SLOT_W(FIELD_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .wr(we && sel[N_MASK+j]), .mode(mode),
            .wdata(wdata), .value(vals[N_MASK+j]),
            .en_pulse(evt_en[MASK_EVT + j*P_SLOTS +: P_SLOTS]),
            .dis_pulse(evt_dis[MASK_EVT + j*P_SLOTS +: P_SLOTS])
        );
    end

    // read mux: zero when nothing is selected
    always_comb begin
        rdata = '0;
        for (int r = 0; r < N_REGS; r++)
            if (sel[r]) rdata = rdata | vals[r];
    end

    // error pulse for a write that hits no register
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= we && (sel == '0);
    end

    // R11
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ((evt_en | evt_dis) == '0) && $past(we));

endmodule

// File: tb/tb_intc_dual_bank.sv
// Directed bench for intc_dual_bank with default parameters.
module tb_intc_dual_bank;

    localparam int NE = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     addr = '0;
    logic [7:0]      wdata = '0;
    logic            we = 1'b0;
    logic [7:0]      rdata;
    logic [NE-1:0]   evt_en;
    logic [NE-1:0]   evt_dis;
    logic            err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    intc_dual_bank dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .evt_en(evt_en), .evt_dis(evt_dis), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // write, then sample pulses in the cycle after the strobe edge
    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic expect_evt(input string tag, input logic [NE-1:0] en, input logic [NE-1:0] dis);
        check({tag, " en"}, 32'(evt_en), 32'(en));
        check({tag, " dis"}, 32'(evt_dis), 32'(dis));
        check({tag, " err"}, 32'(err), 32'd0);
    endtask

    task automatic rd(input string tag, input logic [31:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic t_reset;
        check("R1 en", 32'(evt_en), 32'd0);
        check("R1 dis", 32'(evt_dis), 32'd0);
        check("R1 err", 32'(err), 32'd0);
        rd("R1 mask0", 32'h40, 8'h00);
        rd("R1 prio1", 32'h58, 8'h00);
    endtask

    task automatic t_mask_dual;
        wr(32'h40, 8'h81);              // R3 bits 7,0 -> slots 0,7
        expect_evt("R3 R6 first set", 20'h00081, 20'h0);
        wr(32'h40, 8'h03);              // R7 only bit1 new -> slot 6
        expect_evt("R7 set partial", 20'h00040, 20'h0);
        rd("R10 via set addr", 32'h40, 8'h83);
        @(negedge clk);
        expect_evt("R8 pulse one cycle", 20'h0, 20'h0);
        wr(32'h44, 8'h81);              // R4 clear bits 7,0
        expect_evt("R4 clear", 20'h0, 20'h00081);
        rd("R4 value", 32'h44, 8'h02);
        rd("R10 via clr addr", 32'h40, 8'h02);
    endtask

    task automatic t_upper_bits;
        wr(32'hE000_0040, 8'h10);       // R2 bit4 -> slot 3
        expect_evt("R2 alias write", 20'h00008, 20'h0);
        rd("R2 value", 32'h40, 8'h12);
        rd("R2 alias read", 32'hA000_0040, 8'h12);
    endtask

    task automatic t_single_and_shadow;
        wr(32'h48, 8'h0F);              // R5/R9 mask1 direct, bits0-3 -> idx 15..12
        expect_evt("R9 R5 mask1 direct", 20'h0F000, 20'h0);
        rd("R9 prio0 untouched", 32'h50, 8'h00);
        rd("R5 mask1 value", 32'h48, 8'h0F);
        wr(32'h48, 8'h3C);
        expect_evt("R5 R7 mask1 replace", 20'h00C00, 20'h0C000);
    endtask

    task automatic t_prio_dual;
        wr(32'h50, 8'hA0);              // R6 field 7:4 -> slot 0 -> idx 16
        expect_evt("R6 prio0 slot0", 20'h10000, 20'h0);
        wr(32'h50, 8'h05);
        expect_evt("R6 prio0 slot1", 20'h20000, 20'h0);
        wr(32'h50, 8'h0A);              // R7 5 -> F, nonzero change
        expect_evt("R7 prio0 nonzero change", 20'h20000, 20'h0);
        rd("R3 prio0 value", 32'h50, 8'hAF);
    endtask

    task automatic t_prio_direct;
        wr(32'h58, 8'h30);
        expect_evt("R5 prio1 slot0 on", 20'h40000, 20'h0);
        wr(32'h58, 8'h03);              // R7 slot0 to zero, slot1 on
        expect_evt("R7 prio1 swap", 20'h80000, 20'h40000);
        rd("R5 prio1 value", 32'h58, 8'h03);
    endtask

    task automatic t_unmapped;
        wr(32'h0000_0060, 8'hFF);
        check("R11 err", 32'(err), 32'd1);
        check("R11 no en", 32'(evt_en), 32'd0);
        check("R11 no dis", 32'(evt_dis), 32'd0);
        rd("R11 read zero", 32'h60, 8'h00);
        rd("R11 mask0 kept", 32'h40, 8'h12);
        rd("R11 mask1 kept", 32'h48, 8'h3C);
        rd("R11 prio0 kept", 32'h50, 8'hAF);
        rd("R11 prio1 kept", 32'h58, 8'h03);
        @(negedge clk);
        check("R11 err one cycle", 32'(err), 32'd0);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_dual();
        t_upper_bits();
        t_single_and_shadow();
        t_prio_dual();
        t_prio_direct();
        t_unmapped();
        report();
    end

endmodule